// File: doc/BRIEF.md
# Memory-Shadowed Index Register Unit

This unit keeps the live 16-bit index register of a small minicomputer consistent with the memory word that stands in for it. The register has no address of its own. Instead, one memory word acts as its alias. With extend mode on, that word is always absolute word 0. With extend mode off, it is the first word of the bank the program counter is in, so word 0 for the lower bank and octal 040000 for the upper one.

Any index load writes the live register and the alias word in the same cycle. Any CPU memory write that lands on the alias word also changes the live register.

A separate console port examines and deposits memory words. It has a fixed rule of its own: absolute word 0 is always the index register, whatever the mode or bank. Installed memory is two partly populated banks, held in a synchronous register array.

Top module: `xr_shadow_unit`

## Requirements
- R1: The alias word is absolute 0 when `ext_mode` is 1. When `ext_mode` is 0, it is 0 if `pc[14]` is 0 and octal 040000 if `pc[14]` is 1.
- R2: A cycle with `xr_ld_en` high sets `xr_out` to `xr_ld_data` and writes the same value to the alias word at that clock edge.
- R3: A CPU write that takes effect at the current alias address sets `xr_out` to the written data. A CPU write to any other address leaves `xr_out` unchanged.
- R4: CPU writes to octal addresses 1 through 017 change no memory word and do not touch `xr_out`.
- R5: An address is installed when its low 14 bits are below 1024, in either bank. CPU writes to addresses that are not installed are discarded.
- R6: A console request (`con_req` high) is answered one cycle later with `con_done` high for one cycle. An examine returns the word in `con_rdata`, and a deposit (`con_we` high) writes `con_wdata` to the word.
- R7: A console deposit to absolute address 0 also loads `xr_out`, whatever `ext_mode` and `pc` are.
- R8: A console request to an address that is not installed returns `con_nxm` high and `con_rdata` zero, and changes no memory.
- R9: When `xr_ld_en` and `cpu_wr_en` are high in the same cycle, the load takes effect and the CPU write is discarded.
- R10: Reset clears `xr_out` and memory word 0. All other words keep their contents.
- R11: If a CPU-side write and a console deposit hit the same word, or both would load the index register, in the same cycle, the CPU-side value wins.
- R12: An examine in the same cycle as a write to the same word returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | Extend-mode flag; pins the alias word to 0 |
| pc | input | 15 | Program counter; its bank field selects the alias when extend mode is off |
| cpu_wr_en | input | 1 | CPU memory write strobe |
| cpu_wr_addr | input | 15 | CPU write word address |
| cpu_wr_data | input | 16 | CPU write data |
| xr_ld_en | input | 1 | Index register load strobe |
| xr_ld_data | input | 16 | Value to load into the index register |
| con_req | input | 1 | Console request strobe |
| con_we | input | 1 | Console request is a deposit (1) or an examine (0) |
| con_addr | input | 15 | Console word address |
| con_wdata | input | 16 | Console deposit data |
| con_done | output | 1 | Console request answered, one cycle after the request |
| con_nxm | output | 1 | Console address was not installed |
| con_rdata | output | 16 | Examine data |
| xr_out | output | 16 | Live index register |

## Verification
The hardest case to reach from the ports is the split alias. With extend mode off and the PC in the upper bank, a CPU write to word 0 must change memory but not the register. A console deposit to word 0 must change the register but not the upper-bank alias word. Same-cycle collisions between the index load, a CPU write and a console deposit on one word are just as hard to reach. Directed steps flip the PC bank and the mode around such writes, and the console reads back both alias words. A long random phase then draws addresses mostly from a small pool of both aliases, the protected low words, the bank edges and unpopulated words, so that collisions happen often. A behavioural model checks these collisions every cycle.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

   // Which source loads the live index register this cycle
   typedef enum logic [1:0] {
      XS_NONE = 2'd0,
      XS_CON  = 2'd1,
      XS_CPU  = 2'd2,
      XS_LOAD = 2'd3
   } xr_src_e;

   // One write request towards the storage array
   typedef struct packed {
      logic        en;
      logic [31:0] addr;
      logic [31:0] data;
   } wr_req_t;

endpackage

// File: rtl/xrs_addr_map.sv
module xrs_addr_map #(
   parameter int ADDR_W    = 15,
   parameter int BANK_BIT  = 14,
   parameter int BANK_INST = 1024,
   parameter int PHYS_W    = 11
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              installed,
   output logic [PHYS_W-1:0] phys
);
   localparam int BANK_BITS = ADDR_W - BANK_BIT;
   localparam int OFF_W     = PHYS_W - BANK_BITS;

   generate
      if (OFF_W == BANK_BIT) begin : g_full_bank
         // every bank fully populated
         assign installed = 1'b1;
         assign phys      = addr;
      end else begin : g_part_bank
         assign installed = (addr[BANK_BIT-1:0] < BANK_BIT'(BANK_INST));
         assign phys      = {addr[ADDR_W-1:BANK_BIT], addr[OFF_W-1:0]};
      end
   endgenerate

endmodule

// File: rtl/xrs_shadow_sel.sv
module xrs_shadow_sel #(
   parameter int ADDR_W   = 15,
   parameter int BANK_BIT = 14,
   parameter bit BANKED   = 1'b1
) (
   input  logic              ext_mode,
   input  logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] shadow
);
   logic unused_pc_lo;
   assign unused_pc_lo = ^pc[BANK_BIT-1:0];

   generate
      if (BANKED) begin : g_banked
         // alias follows the program bank unless extend mode pins it low
         assign shadow = ext_mode ? '0 : {pc[ADDR_W-1:BANK_BIT], {BANK_BIT{1'b0}}};
      end else begin : g_fixed
         logic unused_sel;
         assign unused_sel = ext_mode ^ (^pc[ADDR_W-1:BANK_BIT]);
         assign shadow     = '0;
      end
   endgenerate

endmodule

// File: rtl/xrs_store.sv
module xrs_store #(
   parameter int DATA_W = 16,
   parameter int PHYS_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_en,
   input  logic [PHYS_W-1:0] lo_addr,
   input  logic [DATA_W-1:0] lo_data,
   input  logic              hi_en,
   input  logic [PHYS_W-1:0] hi_addr,
   input  logic [DATA_W-1:0] hi_data,
   input  logic              rd_en,
   input  logic [PHYS_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << PHYS_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // the high-priority port is written last, so it wins on a shared word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem[0] <= '0;
      end else begin
         if (lo_en) mem[lo_addr] <= lo_data;
         if (hi_en) mem[hi_addr] <= hi_data;
      end
   end

   // read returns the word as it was before this edge's writes
   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_en)  rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/xrs_xreg.sv
module xrs_xreg
   import xrs_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              cpu_hit,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              con_hit,
   input  logic [DATA_W-1:0] con_data,
   output logic [DATA_W-1:0] xr
);
   xr_src_e src;

   always_comb begin
      if (ld_en)        src = XS_LOAD;
      else if (cpu_hit) src = XS_CPU;
      else if (con_hit) src = XS_CON;
      else              src = XS_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xr <= '0;
      end else begin
         unique case (src)
            XS_LOAD: xr <= ld_data;
            XS_CPU:  xr <= cpu_data;
            XS_CON:  xr <= con_data;
            default: xr <= xr;
         endcase
      end
   end

   // R2 and R9: a load always lands, whatever else hits the register
   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> xr == $past(ld_data));

   // R3: without a hit the register keeps its value
   assert_xr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_en || cpu_hit || con_hit) |=> $stable(xr));

   // R11: CPU-side hit beats a console hit in the same cycle
   assert_cpu_over_con_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hit && !ld_en) |=> xr == $past(cpu_data));

endmodule

// File: rtl/xr_shadow_unit.sv
module xr_shadow_unit #(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 15,
   parameter int BANK_BIT     = 14,
   parameter int BANK_INST    = 1024,
   parameter int LOW_PROT_TOP = 15,
   parameter bit BANKED       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic [ADDR_W-1:0] pc,
   input  logic              cpu_wr_en,
   input  logic [ADDR_W-1:0] cpu_wr_addr,
   input  logic [DATA_W-1:0] cpu_wr_data,
   input  logic              xr_ld_en,
   input  logic [DATA_W-1:0] xr_ld_data,
   input  logic              con_req,
   input  logic              con_we,
   input  logic [ADDR_W-1:0] con_addr,
   input  logic [DATA_W-1:0] con_wdata,
   output logic              con_done,
   output logic              con_nxm,
   output logic [DATA_W-1:0] con_rdata,
   output logic [DATA_W-1:0] xr_out
);
   localparam int OFF_W     = $clog2(BANK_INST);
   localparam int BANK_BITS = ADDR_W - BANK_BIT;
   localparam int PHYS_W    = BANK_BITS + OFF_W;

   // elaboration-time parameter checks
   generate
      if (BANK_BIT >= ADDR_W || BANK_BIT < 1) begin : g_bad_bank
         $error("bank bit must lie inside the address");
      end
      if (BANK_INST < 2 || BANK_INST > (1 << BANK_BIT)) begin : g_bad_inst
         $error("installed words per bank out of range");
      end
      if (LOW_PROT_TOP < 0 || LOW_PROT_TOP >= BANK_INST) begin : g_bad_prot
         $error("protected low window must sit inside installed memory");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("data width too small");
      end
   endgenerate

   // alias location of the index register
   logic [ADDR_W-1:0] shadow_addr;
   xrs_shadow_sel #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT), .BANKED(BANKED)) u_shadow (
      .ext_mode (ext_mode),
      .pc       (pc),
      .shadow   (shadow_addr)
   );

   // address decode for the three address sources
   logic              cpu_inst, con_inst, sh_inst;
   logic [PHYS_W-1:0] cpu_phys, con_phys, sh_phys;

   xrs_addr_map #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT), .BANK_INST(BANK_INST), .PHYS_W(PHYS_W)) u_map_cpu (
      .addr (cpu_wr_addr), .installed (cpu_inst), .phys (cpu_phys)
   );
   xrs_addr_map #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT), .BANK_INST(BANK_INST), .PHYS_W(PHYS_W)) u_map_con (
      .addr (con_addr), .installed (con_inst), .phys (con_phys)
   );
   xrs_addr_map #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT), .BANK_INST(BANK_INST), .PHYS_W(PHYS_W)) u_map_sh (
      .addr (shadow_addr), .installed (sh_inst), .phys (sh_phys)
   );

   logic unused_sh;
   assign unused_sh = sh_inst;

   // CPU side: load has the port, a plain write needs a writable address
   logic cpu_low_prot, cpu_ok;
   assign cpu_low_prot = (cpu_wr_addr != '0) && (cpu_wr_addr <= ADDR_W'(LOW_PROT_TOP));
   assign cpu_ok       = cpu_wr_en && !xr_ld_en && cpu_inst && !cpu_low_prot;

   logic              cpu_port_en;
   logic [PHYS_W-1:0] cpu_port_addr;
   logic [DATA_W-1:0] cpu_port_data;
   assign cpu_port_en   = xr_ld_en || cpu_ok;
   assign cpu_port_addr = xr_ld_en ? sh_phys    : cpu_phys;
   assign cpu_port_data = xr_ld_en ? xr_ld_data : cpu_wr_data;

   // console side: any installed word, no low-window protection
   logic con_dep_ok, con_ex_ok;
   assign con_dep_ok = con_req &&  con_we && con_inst;
   assign con_ex_ok  = con_req && !con_we && con_inst;

   logic [DATA_W-1:0] rd_word;
   xrs_store #(.DATA_W(DATA_W), .PHYS_W(PHYS_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_en   (con_dep_ok),
      .lo_addr (con_phys),
      .lo_data (con_wdata),
      .hi_en   (cpu_port_en),
      .hi_addr (cpu_port_addr),
      .hi_data (cpu_port_data),
      .rd_en   (con_ex_ok),
      .rd_addr (con_phys),
      .rd_data (rd_word)
   );

   // live register: alias hits from each side
   logic cpu_hit, con_hit;
   assign cpu_hit = cpu_ok && (cpu_wr_addr == shadow_addr);
   assign con_hit = con_dep_ok && (con_addr == '0);

   xrs_xreg #(.DATA_W(DATA_W)) u_xreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (xr_ld_en),
      .ld_data  (xr_ld_data),
      .cpu_hit  (cpu_hit),
      .cpu_data (cpu_wr_data),
      .con_hit  (con_hit),
      .con_data (con_wdata),
      .xr       (xr_out)
   );

   // console response
   logic done_q, nxm_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         nxm_q  <= 1'b0;
      end else begin
         done_q <= con_req;
         nxm_q  <= con_req && !con_inst;
      end
   end
   assign con_done  = done_q;
   assign con_nxm   = nxm_q;
   assign con_rdata = nxm_q ? '0 : rd_word;

   // R4: a protected low address never reaches the array from a plain write
   assert_low_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_en && !xr_ld_en && cpu_low_prot) |-> !cpu_port_en);

   // R6: each request is answered exactly one cycle later
   assert_done_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      con_req |=> con_done);
   assert_no_spurious_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !con_req |=> !con_done);

   // R8: an uninstalled console address reports the error with zero data
   assert_nxm_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (con_req && !con_inst) |=> (con_nxm && con_rdata == '0));

endmodule

// File: tb/sim_xr_shadow_unit.sv
module sim_xr_shadow_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_mode = 1'b0;
   logic [14:0] pc = '0;
   logic        cpu_wr_en = 1'b0;
   logic [14:0] cpu_wr_addr = '0;
   logic [15:0] cpu_wr_data = '0;
   logic        xr_ld_en = 1'b0;
   logic [15:0] xr_ld_data = '0;
   logic        con_req = 1'b0;
   logic        con_we = 1'b0;
   logic [14:0] con_addr = '0;
   logic [15:0] con_wdata = '0;
   logic        con_done, con_nxm;
   logic [15:0] con_rdata, xr_out;

   always #4 clk = ~clk;   // 125 MHz

   xr_shadow_unit u0 (
      .clk (clk), .rst_n (rst_n), .ext_mode (ext_mode), .pc (pc),
      .cpu_wr_en (cpu_wr_en), .cpu_wr_addr (cpu_wr_addr), .cpu_wr_data (cpu_wr_data),
      .xr_ld_en (xr_ld_en), .xr_ld_data (xr_ld_data),
      .con_req (con_req), .con_we (con_we), .con_addr (con_addr), .con_wdata (con_wdata),
      .con_done (con_done), .con_nxm (con_nxm), .con_rdata (con_rdata), .xr_out (xr_out)
   );

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   // behavioural reference state
   logic [15:0] m_xr;
   logic [15:0] m_mem [int];
   bit          e_done, e_nxm, e_rd_chk;
   logic [15:0] e_rdata;

   function automatic bit inst_f(input int a);
      return (a & 16'h3FFF) < 1024;
   endfunction

   function automatic bit cpu_wr_ok(input int a);
      return inst_f(a) && (a == 0 || a >= 16);
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // one clock: drive at the falling edge, step the model, compare at the next falling edge
   task automatic cyc(input bit ext, input int pcv,
                      input bit cw, input int ca, input int cd,
                      input bit ld, input int ldd,
                      input bit cr, input bit cwe, input int cad, input int cwd,
                      input string tag);
      int sh;
      logic [15:0] nxr;
      ext_mode = ext; pc = 15'(pcv);
      cpu_wr_en = cw; cpu_wr_addr = 15'(ca); cpu_wr_data = 16'(cd);
      xr_ld_en = ld; xr_ld_data = 16'(ldd);
      con_req = cr; con_we = cwe; con_addr = 15'(cad); con_wdata = 16'(cwd);
      // model next state from pre-edge values
      sh = ext ? 0 : (pcv & 16'h4000);
      e_done = cr;
      e_nxm  = cr && !inst_f(cad);
      e_rd_chk = cr && !cwe && inst_f(cad) && m_mem.exists(cad);
      e_rdata = e_rd_chk ? m_mem[cad] : 16'h0;
      nxr = m_xr;
      if (cr && cwe && cad == 0) nxr = 16'(cwd);
      if (cw && !ld && cpu_wr_ok(ca) && ca == sh) nxr = 16'(cd);
      if (ld) nxr = 16'(ldd);
      if (cr && cwe && inst_f(cad)) m_mem[cad] = 16'(cwd);
      if (cw && !ld && cpu_wr_ok(ca)) m_mem[ca] = 16'(cd);
      if (ld) m_mem[sh] = 16'(ldd);
      m_xr = nxr;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "xr_out", xr_out, m_xr);
      chk("R6", "con_done", con_done, e_done);
      if (e_done) chk("R8", "con_nxm", con_nxm, e_nxm);
      if (e_done && e_nxm) chk("R8", "nxm rdata", con_rdata, 0);
      if (e_rd_chk) chk(tag, "con_rdata", con_rdata, e_rdata);
   endtask

   task automatic idle(input string tag);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic examine(input bit ext, input int pcv, input int a, input string tag);
      cyc(ext, pcv, 0, 0, 0, 0, 0, 1, 0, a, 0, tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cpu_wr_en = 0; xr_ld_en = 0; con_req = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      m_xr = 16'h0;
      m_mem[0] = 16'h0;
      rst_n = 1'b1;
   endtask

   function automatic int pick_addr();
      int r;
      r = $urandom_range(0, 11);
      case (r)
         0: return 0;
         1: return 'o40000;
         2: return 1;
         3: return 'o17;
         4: return 'o20;
         5: return 'o40001;
         6: return 1023;
         7: return 'o40000 + 1023;
         8: return 1024;
         9: return 'o77777;
         default: return $urandom_range(0, 2047) + (($urandom_range(0, 1) != 0) ? 'o40000 : 0);
      endcase
   endfunction

   initial begin
      do_reset();
      // R10: reset state visible at the ports
      chk("R10", "xr after first reset", xr_out, 0);
      // fill installed memory through the console
      for (int i = 0; i < 2048; i++) begin
         int a;
         a = (i < 1024) ? i : ('o40000 + i - 1024);
         cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, a, (a ^ 16'hA5A5) & 16'hFFFF, "R6");
      end
      // R10: reset clears register and word 0 only
      cyc(0, 0, 0, 0, 0, 1, 16'h4321, 0, 0, 0, 0, "R2");
      do_reset();
      chk("R10", "xr after second reset", xr_out, 0);
      examine(0, 0, 0, "R10");
      examine(0, 0, 'o40000, "R10");
      examine(0, 0, 'o20, "R10");

      // R1 / R2: load goes to the bank-relative alias
      cyc(0, 'o100, 0, 0, 0, 1, 16'h1234, 0, 0, 0, 0, "R2");
      examine(0, 'o100, 0, "R1");
      cyc(0, 'o40100, 0, 0, 0, 1, 16'h5555, 0, 0, 0, 0, "R2");
      examine(0, 'o40100, 'o40000, "R1");
      examine(0, 'o40100, 0, "R1");
      cyc(1, 'o40100, 0, 0, 0, 1, 16'h7777, 0, 0, 0, 0, "R2");
      examine(1, 'o40100, 0, "R1");
      examine(1, 'o40100, 'o40000, "R1");

      // R3: write to alias vs write to the other bank's word 0
      cyc(0, 'o40200, 1, 'o40000, 16'hBEEF, 0, 0, 0, 0, 0, 0, "R3");
      cyc(0, 'o40200, 1, 0, 16'hCAFE, 0, 0, 0, 0, 0, 0, "R3");
      examine(0, 'o40200, 0, "R3");
      cyc(1, 'o40200, 1, 0, 16'hD00D, 0, 0, 0, 0, 0, 0, "R3");
      chk("R3", "xr after ext write to 0", xr_out, 16'hD00D);

      // R4: protected low words
      cyc(0, 0, 1, 5, 16'h1111, 0, 0, 0, 0, 0, 0, "R4");
      cyc(0, 0, 1, 'o17, 16'h2222, 0, 0, 0, 0, 0, 0, "R4");
      cyc(0, 0, 1, 'o20, 16'h3333, 0, 0, 0, 0, 0, 0, "R4");
      examine(0, 0, 5, "R4");
      examine(0, 0, 'o17, "R4");
      examine(0, 0, 'o20, "R4");

      // R5: uninstalled word
      cyc(0, 0, 1, 1024, 16'h4444, 0, 0, 0, 0, 0, 0, "R5");
      examine(0, 0, 1024, "R5");
      examine(0, 0, 1023, "R5");

      // R7: console deposit to 0 loads the register in any mode or bank
      cyc(0, 'o40000, 0, 0, 0, 0, 0, 1, 1, 0, 16'h6060, "R7");
      chk("R7", "xr after console deposit", xr_out, 16'h6060);
      examine(0, 'o40000, 'o40000, "R7");
      cyc(1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 16'h7070, "R7");

      // R8: out-of-range console access
      examine(0, 0, 'o77777, "R8");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 'o3000, 16'hAAAA, "R8");
      examine(0, 0, 'o3000, "R8");

      // R9: load and CPU write together
      cyc(0, 0, 1, 0, 16'h0BAD, 1, 16'h900D, 0, 0, 0, 0, "R9");
      chk("R9", "xr after collision", xr_out, 16'h900D);
      cyc(0, 0, 1, 'o30, 16'h0BAD, 1, 16'h1357, 0, 0, 0, 0, "R9");
      examine(0, 0, 'o30, "R9");

      // R11: CPU side beats console on the same word and on the register
      cyc(0, 0, 1, 'o31, 16'hC1C1, 0, 0, 1, 1, 'o31, 16'hC2C2, "R11");
      examine(0, 0, 'o31, "R11");
      cyc(1, 0, 1, 0, 16'hE1E1, 0, 0, 1, 1, 0, 16'hE2E2, "R11");
      chk("R11", "xr after cpu/console clash", xr_out, 16'hE1E1);

      // R12: examine sees the word before a same-cycle write
      cyc(0, 0, 1, 'o40, 16'hF00F, 0, 0, 1, 0, 'o40, 0, "R12");
      examine(0, 0, 'o40, "R12");

      // random phase over alias-heavy addresses
      for (int n = 0; n < 6000; n++) begin
         bit cw, ld, cr;
         cw = ($urandom_range(0, 2) == 0);
         ld = ($urandom_range(0, 5) == 0);
         cr = ($urandom_range(0, 2) == 0);
         cyc($urandom_range(0, 3) == 0, $urandom_range(0, 32767),
             cw, pick_addr(), $urandom_range(0, 65535),
             ld, $urandom_range(0, 65535),
             cr, $urandom_range(0, 1) != 0, pick_addr(), $urandom_range(0, 65535),
             "R3");
      end
      idle("R3");

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule